// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Sequencer

This block is the address and control front end of a synchronous flow-through burst SRAM. On each rising clock edge it looks at two active-low burst-start strobes. One is a processor strobe and one is a controller strobe. When either strobe is active, the block registers the external word address and whether the three chip enables select the device. While no strobe is active, a two-bit beat counter produces the other three words of a four-word burst. The counter steps only in cycles where the active-low advance input is asserted.

A static mode input picks the burst order. High gives interleaved order, where the low address bits are the start bits XOR the beat count. Low gives linear order, where the low address bits are the start bits plus the beat count, modulo four. The upper address bits are fixed for the whole burst. The registered word address drives a small parameterised behavioural memory array. Its read data is flow-through: a combinational read of the registered address, with no output register.

Writes can happen in two ways. A controller-strobe edge can perform a single write to the newly presented address. At a continuation edge, a write goes to the word the burst currently points at. A processor-strobe edge always ignores the write control.

Top module: `burst_sram_seq`

## Requirements
- R1: While rst is high at a clock edge, the block is deselected after that edge: sel_o is 0, word_addr_o is 0 and rdata_o is 0.
- R2: A burst starts at an edge where adsc_n is 0, or where adsp_n is 0 together with ce1_n at 0. From the next cycle, word_addr_o equals the addr_i sampled at that edge. When ce1_n is 1, adsp_n is ignored, but adsc_n is still honoured.
- R3: At a burst-start edge, sel_o is loaded with 1 only if ce1_n is 0, ce2 is 1 and ce3_n is 0. Otherwise it is loaded with 0. sel_o then holds until the next burst-start edge.
- R4: At an edge with no burst start, the beat count advances by one only when adv_n is 0. When adv_n is 1, word_addr_o and sel_o hold their values.
- R5: With mode_i at 0 (linear order), after k advances the two low bits of word_addr_o are (s + k) mod 4, where s is the two low bits of the start address.
- R6: With mode_i at 1 (interleaved order), after k advances the two low bits of word_addr_o are s XOR (k mod 4).
- R7: Advancing past the fourth beat wraps back to the start word. The bits of word_addr_o above bit 1 never change without a burst start.
- R8: When sel_o is 1, rdata_o is the memory word at word_addr_o in the same cycle. When sel_o is 0, rdata_o is 0.
- R9: At an edge with no burst start, with we_n at 0 and sel_o at 1, the word at word_addr_o is replaced by wdata_i. The advance at that same edge still applies.
- R10: At a controller-strobe start edge (adsc_n is 0 and the processor start is not in effect), if we_n is 0 and all three enables are active, wdata_i is written at addr_i.
- R11: If both strobes are 0 with ce1_n at 0, the processor start takes priority and the write control at that edge is ignored.
- R12: A write control is ignored while the block is deselected. This covers a controller-strobe edge with any enable inactive, and a continuation edge with sel_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| adsp_n | input | 1 | Processor burst-start strobe, active low |
| adsc_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low; also gates adsp_n |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3_n | input | 1 | Depth-expansion enable, active low |
| we_n | input | 1 | Write control, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata_i | input | DATA_W | Write data |
| word_addr_o | output | ADDR_W | Registered current word address |
| sel_o | output | 1 | Device selected for the current burst |
| rdata_o | output | DATA_W | Flow-through read data, zero when deselected |

## Verification
The checker verifies these properties on every cycle:
- the capture of addr_i at any start edge;
- the loading of sel_o from the enables;
- the hold of address and select when adv_n is high;
- the fixed upper address bits;
- the plus-one step of the linear order;
- the zero read data while deselected;
- the reset state.

Only the bench scenarios can show the rest. This includes the full interleaved sequence and its wrap for every start address. It also includes what the memory holds after controller-strobe writes and burst writes, and that writes are really dropped under strobe priority or deselection. A reference memory read back through rdata_o reveals these.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } burst_src_e;

  // Low address bits of beat k of a burst starting at low bits s.
  function automatic logic [BEAT_W-1:0] burst_low(
    input logic [BEAT_W-1:0] s,
    input logic [BEAT_W-1:0] k,
    input logic              interleave
  );
    return interleave ? (s ^ k) : (s + k);
  endfunction

endpackage

// File: rtl/burst_strobe_dec.sv
`timescale 1ns/1ps
module burst_strobe_dec
  import burst_sram_pkg::*;
(
  input  logic       adsp_n,
  input  logic       adsc_n,
  input  logic       ce1_n,
  input  logic       ce2,
  input  logic       ce3_n,
  input  logic       we_n,
  input  logic       sel_q,
  output burst_src_e src,
  output logic       start,
  output logic       chip_ok,
  output logic       wr_en,
  output logic       wr_from_port
);

  always_comb begin
    chip_ok = !ce1_n && ce2 && !ce3_n;
    // processor strobe wins, but only when the primary enable is active
    if (!adsp_n && !ce1_n)
      src = SRC_PROC;
    else if (!adsc_n)
      src = SRC_CTRL;
    else
      src = SRC_NONE;
    start = (src != SRC_NONE);
    unique case (src)
      SRC_PROC: wr_en = 1'b0;
      SRC_CTRL: wr_en = !we_n && chip_ok;
      default:  wr_en = !we_n && sel_q;
    endcase
    wr_from_port = (src == SRC_CTRL);
  end

endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              chip_ok,
  input  logic              adv_n,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_q
);

  logic [BEAT_W-1:0] base_lo;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] next_beat;
  logic              step;

  always_comb begin
    step      = !start && !adv_n;
    next_beat = beat + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      sel_q   <= 1'b0;
      base_lo <= '0;
      beat    <= '0;
    end else if (start) begin
      addr_q  <= addr_i;
      sel_q   <= chip_ok;
      base_lo <= addr_i[BEAT_W-1:0];
      beat    <= '0;
    end else if (step) begin
      beat                 <= next_beat;
      addr_q[BEAT_W-1:0]   <= burst_low(base_lo, next_beat, mode_i);
    end
  end

endmodule

// File: rtl/burst_mem.sv
`timescale 1ns/1ps
module burst_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // flow-through: combinational read of the registered address
  assign rdata = mem[raddr];

endmodule

// File: rtl/burst_sram_seq.sv
`timescale 1ns/1ps
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              sel_o,
  output logic [DATA_W-1:0] rdata_o
);

  burst_src_e        src;
  logic              start;
  logic              chip_ok;
  logic              wr_en;
  logic              wr_from_port;
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] mem_rd;

  burst_strobe_dec u_dec (
    .adsp_n      (adsp_n),
    .adsc_n      (adsc_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .we_n        (we_n),
    .sel_q       (sel_q),
    .src         (src),
    .start       (start),
    .chip_ok     (chip_ok),
    .wr_en       (wr_en),
    .wr_from_port(wr_from_port)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .chip_ok(chip_ok),
    .adv_n  (adv_n),
    .mode_i (mode_i),
    .addr_i (addr_i),
    .addr_q (addr_q),
    .sel_q  (sel_q)
  );

  assign wr_addr = wr_from_port ? addr_i : addr_q;

  burst_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wdata_i),
    .raddr(addr_q),
    .rdata(mem_rd)
  );

  assign word_addr_o = addr_q;
  assign sel_o       = sel_q;
  assign rdata_o     = sel_q ? mem_rd : '0;

endmodule

// File: rtl/burst_sram_seq_chk.sv
`timescale 1ns/1ps
module burst_sram_seq_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              mode_i,
  input logic [ADDR_W-1:0] word_addr_o,
  input logic              sel_o,
  input logic [DATA_W-1:0] rdata_o
);

  logic begin_burst;
  assign begin_burst = (!adsp_n && !ce1_n) || !adsc_n;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!sel_o && word_addr_o == '0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    begin_burst |=> word_addr_o == $past(addr_i));

  assert_select_R3: assert property (@(posedge clk) disable iff (rst)
    begin_burst |=> sel_o == $past(!ce1_n && ce2 && !ce3_n));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!begin_burst && adv_n) |=> ($stable(word_addr_o) && $stable(sel_o)));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!begin_burst && !adv_n && !mode_i) |=>
      word_addr_o[1:0] == 2'($past(word_addr_o[1:0]) + 2'd1));

  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    !begin_burst |=> word_addr_o[ADDR_W-1:2] == $past(word_addr_o[ADDR_W-1:2]));

  assert_gated_read_R8: assert property (@(posedge clk) disable iff (rst)
    !sel_o |-> rdata_o == '0);

endmodule

bind burst_sram_seq burst_sram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr_i     (addr_i),
  .adsp_n     (adsp_n),
  .adsc_n     (adsc_n),
  .adv_n      (adv_n),
  .ce1_n      (ce1_n),
  .ce2        (ce2),
  .ce3_n      (ce3_n),
  .mode_i     (mode_i),
  .word_addr_o(word_addr_o),
  .sel_o      (sel_o),
  .rdata_o    (rdata_o)
);

// File: tb/burst_sram_seq_tb.sv
`timescale 1ns/1ps
module burst_sram_seq_tb_top;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, we_n, mode_i;
  logic [DW-1:0] wdata_i;
  logic [AW-1:0] word_addr_o;
  logic          sel_o;
  logic [DW-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_addr;
  logic          m_sel;
  logic [1:0]    m_s, m_k;

  always #2.5 clk = ~clk;

  burst_sram_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
    .mode_i(mode_i), .wdata_i(wdata_i), .word_addr_o(word_addr_o),
    .sel_o(sel_o), .rdata_o(rdata_o)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 16'h3b1 + 16'h1234);
  endfunction

  // Drive one cycle, update the model from the requirements, compare after the edge.
  task automatic step(input logic p, input logic c, input logic v, input logic w,
                      input logic e1, input logic e2, input logic e3,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    logic proc, st, ok;
    logic [DW-1:0] exp_rd;
    adsp_n = p; adsc_n = c; adv_n = v; we_n = w;
    ce1_n = e1; ce2 = e2; ce3_n = e3; addr_i = a; wdata_i = d;
    proc = !p && !e1;
    st   = proc || !c;
    ok   = !e1 && e2 && !e3;
    if (!proc && !c) begin
      if (!w && ok) ref_mem[a] = d;              // R10
    end else if (!st && !w && m_sel) begin
      ref_mem[m_addr] = d;                       // R9
    end
    if (st) begin
      m_addr = a; m_s = a[1:0]; m_k = 2'd0; m_sel = ok;
    end else if (!v) begin
      m_k = m_k + 2'd1;
      m_addr[1:0] = mode_i ? (m_s ^ m_k) : (m_s + m_k);
    end
    @(posedge clk); #1;
    exp_rd = m_sel ? ref_mem[m_addr] : '0;
    checks++;
    if (word_addr_o !== m_addr || sel_o !== m_sel || rdata_o !== exp_rd) begin
      errors++;
      $display("FAIL %s: addr %0h exp %0h, sel %0b exp %0b, data %0h exp %0h",
               tag, word_addr_o, m_addr, sel_o, m_sel, rdata_o, exp_rd);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; adsp_n = 1; adsc_n = 1; adv_n = 1; we_n = 1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; mode_i = 0; addr_i = '0; wdata_i = '0;
    m_addr = '0; m_sel = 0; m_s = '0; m_k = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (sel_o !== 1'b0 || word_addr_o !== '0 || rdata_o !== '0) begin
      errors++;
      $display("FAIL R1 reset: sel %0b addr %0h data %0h exp 0 0 0", sel_o, word_addr_o, rdata_o);
    end
    rst = 1'b0;

    // R10: fill every word with controller-strobe writes
    for (int a = 0; a < DEPTH; a++)
      step(1, 0, 1, 0, 0, 1, 0, AW'(a), pat(a), "R10 fill");

    // R2 R5 R6 R7 R8: every start address, both orders, six advances (wraps)
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      for (int a = 0; a < DEPTH; a++) begin
        step(0, 1, 1, 1, 0, 1, 0, AW'(a), '0, "R2 start");
        for (int b = 1; b <= 6; b++)
          step(1, 1, 0, 1, 0, 1, 0, '0, '0, (b > 3) ? "R7 wrap" : (m == 1 ? "R6 beat" : "R5 beat"));
      end
    end

    // R4: hold with adv_n high
    mode_i = 0;
    step(0, 1, 1, 1, 0, 1, 0, AW'(5), '0, "R2 start");
    step(1, 1, 1, 1, 0, 1, 0, '0, '0, "R4 hold");
    step(1, 1, 1, 1, 0, 1, 0, '0, '0, "R4 hold");
    step(1, 1, 0, 1, 0, 1, 0, '0, '0, "R4 step");
    step(1, 1, 1, 1, 0, 1, 0, '0, '0, "R4 hold");
    // R2: restart mid-burst, then processor strobe ignored with ce1_n high
    step(1, 0, 0, 1, 0, 1, 0, AW'(40), '0, "R2 restart");
    step(0, 1, 0, 1, 1, 1, 0, AW'(9), '0, "R2 adsp ignored");
    step(0, 1, 1, 1, 1, 1, 0, AW'(9), '0, "R2 adsp ignored");

    // R3: each enable alone deselects; ADSC honoured with ce1_n high
    step(1, 0, 1, 1, 1, 1, 0, AW'(12), '0, "R3 ce1 off");
    step(1, 0, 1, 1, 0, 0, 0, AW'(13), '0, "R3 ce2 off");
    step(1, 0, 1, 1, 0, 1, 1, AW'(14), '0, "R3 ce3 off");
    step(1, 1, 0, 1, 0, 1, 0, '0, '0, "R3 hold deselect");
    step(1, 0, 1, 1, 0, 1, 0, AW'(14), '0, "R3 selected");

    // R9: burst write in interleaved order, then read back
    mode_i = 1;
    step(0, 1, 1, 1, 0, 1, 0, AW'(42), '0, "R9 start");
    for (int b = 0; b < 4; b++)
      step(1, 1, 0, 0, 0, 1, 0, '0, DW'(16'hA000 + b), "R9 write");
    step(0, 1, 1, 1, 0, 1, 0, AW'(42), '0, "R9 readback");
    for (int b = 0; b < 3; b++)
      step(1, 1, 0, 1, 0, 1, 0, '0, '0, "R9 readback");

    // R11: both strobes, write ignored
    step(0, 0, 1, 0, 0, 1, 0, AW'(17), 16'hBEEF, "R11 priority");
    step(1, 0, 1, 1, 0, 1, 0, AW'(17), '0, "R11 readback");

    // R12: deselected writes dropped
    step(1, 0, 1, 0, 0, 0, 0, AW'(18), 16'hDEAD, "R12 ctrl deselected");
    step(1, 1, 0, 0, 0, 1, 0, '0, 16'hCAFE, "R12 burst deselected");
    step(1, 1, 0, 0, 0, 1, 0, '0, 16'hCAFE, "R12 burst deselected");
    step(1, 0, 1, 1, 0, 1, 0, AW'(18), '0, "R12 readback");
    step(1, 1, 0, 1, 0, 1, 0, '0, '0, "R12 readback");
    step(1, 1, 0, 1, 0, 1, 0, '0, '0, "R12 readback");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule